// File: doc/BRIEF.md
# UART Receive Control-Character Recognizer

This block sits behind a UART receiver and inspects every received byte against a small programmable table of control characters. Each table entry holds a character code, a valid bit and two policy bits: a reject bit, which keeps a matched character out of the receive buffer, and an empty bit, which decides whether a stored match also ends the current buffer. Unmatched bytes pass through as ordinary data. Bytes that are stored appear on a buffer write strobe. A close pulse accompanies the byte that ends a buffer, so the buffer can be handed to the host.

A rejected match is copied into a last-control-character register and raises a sticky interrupt, which the host clears with a strobe. Two table slots, fixed by parameter, act as flow-control characters. A rejected match on the stop slot sets a transmit freeze flag. A rejected match on the resume slot clears it. The transmitter halts while the flag is set and resumes at the byte where it stopped. A programmable maximum length also closes a buffer once it has received that many bytes.

Top module: `uccr_top`

## Requirements
- R1: After reset, buf_we_o, buf_close_o, irq_o and tx_freeze_o are 0, and buf_data_o and ctrl_char_o are 8'h00.
- R2: A byte that matches no entry is presented on buf_data_o with buf_we_o high for exactly one cycle, in the cycle after the clock edge that sampled rx_valid_i. No close is raised unless R9 applies.
- R3: A match on an entry with reject=0 and empty=0 is stored as in R2, and buf_close_o pulses in the same cycle as that write.
- R4: A match on an entry with reject=0 and empty=1 is stored without a close from the match itself. It raises no interrupt and leaves ctrl_char_o unchanged.
- R5: A match on an entry with reject=1 produces no buffer write and no close, whatever its empty bit. The byte is loaded into ctrl_char_o and irq_o is set, both visible one cycle after the sampling edge.
- R6: The table is searched from index 0 upward. The first entry whose valid bit is 0 ends the search, so entries above it never match. When several entries hold the same character, the lowest index wins.
- R7: irq_o stays high until irq_clr_i is sampled high. A rejected match sampled in the same cycle as the clear leaves irq_o high. A new rejected match overwrites ctrl_char_o.
- R8: A rejected match on slot XOFF_IDX (default 1) sets tx_freeze_o. A rejected match on slot XON_IDX (default 2) clears it. No other byte changes tx_freeze_o.
- R9: When max_len_i is non-zero, the stored byte that brings the buffer count to max_len_i carries buf_close_o. Every close restarts the count at zero. When max_len_i is 0, no length limit applies.
- R10: A table write (tbl_we_i with tbl_idx_i) applies to bytes sampled after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| tbl_we_i | input | 1 | Table entry write enable |
| tbl_idx_i | input | 2 | Table entry index |
| tbl_char_i | input | 8 | Character code to write |
| tbl_valid_i | input | 1 | Entry valid bit to write |
| tbl_empty_i | input | 1 | Entry empty bit to write |
| tbl_reject_i | input | 1 | Entry reject bit to write |
| max_len_i | input | 8 | Maximum bytes per buffer, 0 for no limit |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_data_o | output | 8 | Byte being written to the buffer |
| buf_close_o | output | 1 | Close current buffer with this write |
| irq_o | output | 1 | Control character received interrupt |
| ctrl_char_o | output | 8 | Last rejected control character |
| tx_freeze_o | output | 1 | Transmit freeze flag |

## Verification
The assertions check on every cycle that a rejected match never produces a write, that a close only travels with a write, that every close resets the length count, that the interrupt holds until it is cleared, and that the freeze flag moves only when a byte is sampled. Other behaviours depend on the table contents, so only the bench scenarios can show them. These are search termination at an invalid entry, lowest-index priority, the effect of the empty bit, the exact close point under a length limit, and the timing of table writes.

// File: rtl/uccr_pkg.sv
package uccr_pkg;
  parameter int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              valid;
    logic              empty;
    logic              reject;
    logic [CHAR_W-1:0] ch;
  } cc_entry_t;
endpackage

// File: rtl/uccr_table.sv
module uccr_table
  import uccr_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  cc_entry_t        wdata_i,
  output cc_entry_t        tbl_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g)) tbl_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/uccr_match.sv
module uccr_match
  import uccr_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  cc_entry_t         tbl_i [N],
  input  logic [CHAR_W-1:0] byte_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              empty_o,
  output logic              reject_o
);
  always_comb begin
    logic live;
    live     = 1'b1;
    hit_o    = 1'b0;
    idx_o    = '0;
    empty_o  = 1'b0;
    reject_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (live && !tbl_i[i].valid) begin
        live = 1'b0;  // first invalid entry ends the search
      end else if (live && !hit_o && tbl_i[i].ch == byte_i) begin
        hit_o    = 1'b1;
        idx_o    = IDX_W'(i);
        empty_o  = tbl_i[i].empty;
        reject_o = tbl_i[i].reject;
      end
    end
  end
endmodule

// File: rtl/uccr_buf_ctrl.sv
module uccr_buf_ctrl
  import uccr_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic              term_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic [LEN_W-1:0]  max_len_i,
  output logic              buf_we_o,
  output logic [CHAR_W-1:0] buf_data_o,
  output logic              buf_close_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_inc;
  logic             at_lim;
  logic             close_d;

  assign cnt_inc = cnt_q + LEN_W'(1);
  assign at_lim  = (max_len_i != '0) && (cnt_inc == max_len_i);
  assign close_d = store_i && (term_i || at_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      buf_we_o    <= 1'b0;
      buf_data_o  <= '0;
      buf_close_o <= 1'b0;
    end else begin
      buf_we_o    <= store_i;
      buf_close_o <= close_d;
      if (store_i) begin
        buf_data_o <= data_i;
        cnt_q      <= close_d ? '0 : cnt_inc;
      end
    end
  end

  p_close_with_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_close_o |-> buf_we_o);

  p_close_clears_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_close_o |-> cnt_q == '0);
endmodule

// File: rtl/uccr_top.sv
module uccr_top
  import uccr_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned XOFF_IDX = 1,
  parameter int unsigned XON_IDX  = 2,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [CHAR_W-1:0] tbl_char_i,
  input  logic              tbl_valid_i,
  input  logic              tbl_empty_i,
  input  logic              tbl_reject_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              irq_clr_i,
  output logic              buf_we_o,
  output logic [CHAR_W-1:0] buf_data_o,
  output logic              buf_close_o,
  output logic              irq_o,
  output logic [CHAR_W-1:0] ctrl_char_o,
  output logic              tx_freeze_o
);
  cc_entry_t        tbl [N];
  cc_entry_t        wentry;
  logic             hit, m_empty, m_reject;
  logic [IDX_W-1:0] m_idx;
  logic             rej_hit, store, term;

  assign wentry = '{valid: tbl_valid_i, empty: tbl_empty_i,
                    reject: tbl_reject_i, ch: tbl_char_i};

  uccr_table #(.N(N), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .idx_i(tbl_idx_i),
    .wdata_i(wentry), .tbl_o(tbl)
  );

  uccr_match #(.N(N), .IDX_W(IDX_W)) u_match (
    .tbl_i(tbl), .byte_i(rx_data_i), .hit_o(hit), .idx_o(m_idx),
    .empty_o(m_empty), .reject_o(m_reject)
  );

  assign rej_hit = rx_valid_i && hit && m_reject;
  assign store   = rx_valid_i && !(hit && m_reject);
  assign term    = hit && !m_reject && !m_empty;

  uccr_buf_ctrl #(.LEN_W(LEN_W)) u_buf (
    .clk_i, .rst_ni, .store_i(store), .term_i(term), .data_i(rx_data_i),
    .max_len_i, .buf_we_o, .buf_data_o, .buf_close_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      ctrl_char_o <= '0;
      tx_freeze_o <= 1'b0;
    end else begin
      if (rej_hit) begin
        irq_o       <= 1'b1;  // set wins over clear
        ctrl_char_o <= rx_data_i;
        if (m_idx == IDX_W'(XOFF_IDX))     tx_freeze_o <= 1'b1;
        else if (m_idx == IDX_W'(XON_IDX)) tx_freeze_o <= 1'b0;
      end else if (irq_clr_i) begin
        irq_o <= 1'b0;
      end
    end
  end

  p_reject_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_hit |=> !buf_we_o);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  p_freeze_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(tx_freeze_o));

  p_irq_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_hit |=> irq_o);
endmodule

// File: tb/uccr_top_tb.sv
module uccr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] rx_data = 0;
  logic       rx_valid = 0;
  logic       tbl_we = 0;
  logic [1:0] tbl_idx = 0;
  logic [7:0] tbl_char = 0;
  logic       tbl_valid = 0, tbl_empty = 0, tbl_reject = 0;
  logic [7:0] max_len = 0;
  logic       irq_clr = 0;
  logic       buf_we, buf_close, irq, tx_freeze;
  logic [7:0] buf_data, ctrl_char;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_ch [4];
  bit         m_v [4], m_e [4], m_r [4];
  logic [7:0] m_cnt = 0, m_last = 0, m_ctrl = 0;
  bit         m_irq = 0, m_frz = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uccr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_char_i(tbl_char),
    .tbl_valid_i(tbl_valid), .tbl_empty_i(tbl_empty), .tbl_reject_i(tbl_reject),
    .max_len_i(max_len), .irq_clr_i(irq_clr),
    .buf_we_o(buf_we), .buf_data_o(buf_data), .buf_close_o(buf_close),
    .irq_o(irq), .ctrl_char_o(ctrl_char), .tx_freeze_o(tx_freeze)
  );

  function automatic int m_find(logic [7:0] b);
    for (int i = 0; i < 4; i++) begin
      if (!m_v[i]) return -1;
      if (m_ch[i] == b) return i;
    end
    return -1;
  endfunction

  function automatic logic [19:0] outs();
    return {buf_we, buf_data, buf_close, irq, ctrl_char, tx_freeze};
  endfunction

  task automatic check(input logic [19:0] act, input logic [19:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h (we,data,close,irq,ctrl,frz)", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input logic [7:0] c, input bit v, input bit e, input bit r);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 2'(idx); tbl_char = c;
    tbl_valid = v; tbl_empty = e; tbl_reject = r;
    m_ch[idx] = c; m_v[idx] = v; m_e[idx] = e; m_r[idx] = r;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit clr, input string req);
    int k;
    bit rej, st, term, cl;
    logic [7:0] nxt;
    @(negedge clk);
    rx_data = b; rx_valid = 1; irq_clr = clr;
    k    = m_find(b);
    rej  = (k >= 0) && m_r[k];
    st   = !rej;
    term = (k >= 0) && !m_r[k] && !m_e[k];
    cl   = 0;
    if (st) begin
      nxt = m_cnt + 8'd1;
      if (term || (max_len != 0 && nxt == max_len)) begin cl = 1; m_cnt = 0; end
      else m_cnt = nxt;
      m_last = b;
    end
    if (rej) begin
      m_ctrl = b; m_irq = 1;
      if (k == 1) m_frz = 1;
      else if (k == 2) m_frz = 0;
    end else if (clr) m_irq = 0;
    @(negedge clk);
    rx_valid = 0; irq_clr = 0;
    check(outs(), {st, m_last, cl, m_irq, m_ctrl, m_frz}, req);
  endtask

  task automatic idle_chk(input bit clr, input string req);
    @(negedge clk);
    irq_clr = clr;
    if (clr) m_irq = 0;
    @(negedge clk);
    irq_clr = 0;
    check(outs(), {1'b0, m_last, 1'b0, m_irq, m_ctrl, m_frz}, req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_ch[i] = 0; m_v[i] = 0; m_e[i] = 0; m_r[i] = 0; end
    repeat (2) @(negedge clk);
    check(outs(), 20'h0, "R1");
    rst_n = 1;
    // table: 0 end-of-line, 1 stop, 2 resume, 3 store-only
    wr_tbl(0, 8'h0A, 1, 0, 0);
    wr_tbl(1, 8'h13, 1, 0, 1);
    wr_tbl(2, 8'h11, 1, 1, 1);
    wr_tbl(3, 8'h2C, 1, 1, 0);
    send(8'h41, 0, "R2");
    send(8'h42, 0, "R2");
    idle_chk(0, "R2");
    send(8'h0A, 0, "R3");
    send(8'h2C, 0, "R4");
    send(8'h13, 0, "R5");
    send(8'h13, 0, "R8");
    idle_chk(0, "R7");
    send(8'h11, 1, "R7");
    send(8'h11, 0, "R8");
    idle_chk(1, "R7");
    idle_chk(0, "R7");
    // R6: invalidate slot 2, slot 3 beyond it must not match
    wr_tbl(2, 8'h11, 0, 1, 1);
    send(8'h2C, 0, "R6");
    send(8'h11, 0, "R6");
    // R6: duplicate char at lower index wins
    wr_tbl(2, 8'h0A, 1, 0, 1);
    send(8'h0A, 0, "R6");
    // R10: write and immediately send
    wr_tbl(2, 8'h55, 1, 0, 1);
    send(8'h55, 0, "R10");
    wr_tbl(2, 8'h11, 1, 1, 1);
    send(8'h55, 0, "R10");
    // R9: length limit
    @(negedge clk); max_len = 3;
    send(8'h61, 0, "R9");
    send(8'h62, 0, "R9");
    send(8'h63, 0, "R9");
    send(8'h64, 0, "R9");
    send(8'h0A, 0, "R9");
    send(8'h65, 0, "R9");
    send(8'h13, 0, "R9");
    send(8'h66, 0, "R9");
    send(8'h67, 0, "R9");
    // R5: reject entry with empty=0 behaves the same as empty=1
    wr_tbl(3, 8'h77, 1, 0, 1);
    send(8'h77, 0, "R5");
    // random mix
    void'($urandom(32'h1234_5678));
    @(negedge clk); max_len = 5;
    for (int it = 0; it < 400; it++) begin
      logic [7:0] b;
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: b = 8'h0A;
        1: b = 8'h13;
        2: b = 8'h11;
        3: b = 8'h77;
        default: b = 8'($urandom);
      endcase
      if (($urandom & 7) == 0) idle_chk($urandom_range(0, 1) == 1, "R7");
      else send(b, ($urandom & 3) == 0, "R2");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule